// File: doc/BRIEF.md
# 100Base-X Receive Symbol Error Monitor

This block sits behind the code-group aligner of a 100 Mb/s receive path. It watches one 5-bit 4B/5B code group per valid strobe and follows the line through four phases:

- hunting for a start of stream;
- checking the start-delimiter pair;
- inside a frame;
- recovering after a bad start.

While it does so it detects four receive anomalies: a false carrier, an invalid code group inside a frame, a halt code group inside a frame, and a frame cut short by idle line.

Each anomaly raises a one-symbol receive-error pulse toward the MAC side and sets its own latching status bit. A management read strobe clears those bits. The status bits only carry meaning at 100 Mb/s. When the speed select says 10 Mb/s, the bits are forced to zero, the monitor parks in its hunt state and nothing can set the bits.

The block is dropped into a PHY receive path next to the management register file. The register file presents `stat_rd_i` for one cycle when software reads the status word. That cycle's `stat_o` is the value returned.

Top module: `sym_err_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `stat_o` is 0000, `rx_err_o` is 0 and `in_pkt_o` is 0.
- R2: From hunt, idle (11111) keeps hunting. J (11000) followed by K (10001) starts a frame, and `in_pkt_o` is 1 from the edge that takes K. T (01101) followed by R (00111) ends the frame cleanly, and `in_pkt_o` is 0 from the edge that takes R. No status bit or error pulse results from a clean frame.
- R3: False carrier, status bit 0, is set in either of two cases: a non-idle code group other than J arrives while hunting, or J is followed by anything but K. The monitor then ignores J/K until IDLE_RUN (default 2) consecutive idles have arrived, and only then hunts again.
- R4: Inside a frame, a code group that is none of the 16 data groups and none of idle, J, K, T, R, H sets invalid symbol, status bit 1. The frame continues.
- R5: Inside a frame, H (00100) sets halt, status bit 2. `in_pkt_o` drops at that edge and the monitor hunts again.
- R6: Inside a frame, IDLE_RUN consecutive idles before T/R set premature end, status bit 3. `in_pkt_o` drops at that edge and the monitor hunts again. Fewer idles followed by data set nothing.
- R7: `rx_err_o` is 1 for exactly the one cycle after the edge that takes each anomalous code group, and is 0 otherwise.
- R8: A set status bit stays at 1 until an edge where `stat_rd_i` is 1; that edge clears it. `stat_o` in the read cycle shows the old value.
- R9: When an anomaly and `stat_rd_i` meet at the same edge, the anomaly's bit is 1 afterwards.
- R10: An edge with `fast_mode_i` at 0 forces `stat_o` to 0000, `rx_err_o` to 0 and `in_pkt_o` to 0, and returns the monitor to hunting, whatever the code group.
- R11: An edge with `code_vld_i` at 0 changes neither the monitor state nor any status bit, and gives `rx_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | CODE_W | Aligned, decoded-from-NRZI, descrambled 5-bit code group |
| code_vld_i | input | 1 | `code_i` holds a new code group this cycle |
| fast_mode_i | input | 1 | 1 = 100 Mb/s operation, 0 = 10 Mb/s (monitor disabled) |
| stat_rd_i | input | 1 | Status word read strobe; clears the latched bits at this edge |
| stat_o | output | 4 | Latched status bits: [0] false carrier, [1] invalid symbol, [2] halt, [3] premature end |
| rx_err_o | output | 1 | Registered receive-error pulse toward the MAC side |
| in_pkt_o | output | 1 | 1 while the monitor is inside a frame |

## Verification
The bench builds the block with its defaults: CODE_W of 5, an IDLE_RUN of 2 and an error mask that lets all four anomalies pulse `rx_err_o`. An IDLE_RUN of 2 makes the premature-end and recovery thresholds exactly the double idle of the line code. A single idle inside a frame, and a single idle during recovery, can therefore be set against the double idle that ends each. With the full mask, every anomaly is visible on `rx_err_o`, so the error pulse is checked alongside every status bit rising.

// File: rtl/sem_pkg.sv
package sem_pkg;

   localparam int NUM_FLAGS = 4;

   // status bit positions
   localparam int FLG_FALSE   = 0;
   localparam int FLG_INVALID = 1;
   localparam int FLG_HALT    = 2;
   localparam int FLG_EARLY   = 3;

   // control code groups
   localparam logic [4:0] CG_IDLE = 5'b11111;
   localparam logic [4:0] CG_J    = 5'b11000;
   localparam logic [4:0] CG_K    = 5'b10001;
   localparam logic [4:0] CG_T    = 5'b01101;
   localparam logic [4:0] CG_R    = 5'b00111;
   localparam logic [4:0] CG_H    = 5'b00100;

   typedef enum logic [2:0] {
      SC_DATA, SC_IDLE, SC_J, SC_K, SC_T, SC_R, SC_H, SC_BAD
   } sym_class_e;

   typedef enum logic [2:0] {
      ST_HUNT, ST_GOT_J, ST_FRAME, ST_GOT_T, ST_RECOVER
   } mon_state_e;

   function automatic sym_class_e classify(input logic [4:0] cg);
      sym_class_e c;
      unique case (cg)
         CG_IDLE: c = SC_IDLE;
         CG_J:    c = SC_J;
         CG_K:    c = SC_K;
         CG_T:    c = SC_T;
         CG_R:    c = SC_R;
         CG_H:    c = SC_H;
         5'b11110, 5'b01001, 5'b10100, 5'b10101,
         5'b01010, 5'b01011, 5'b01110, 5'b01111,
         5'b10010, 5'b10011, 5'b10110, 5'b10111,
         5'b11010, 5'b11011, 5'b11100, 5'b11101: c = SC_DATA;
         default: c = SC_BAD;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sem_classifier.sv
module sem_classifier
   import sem_pkg::*;
#(
   parameter int CODE_W = 5
) (
   input  logic [CODE_W-1:0] code_i,
   output sym_class_e        cls_o
);

   always_comb cls_o = classify(code_i[4:0]);

endmodule

// File: rtl/sem_frame_fsm.sv
module sem_frame_fsm
   import sem_pkg::*;
#(
   parameter int IDLE_RUN = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable_i,
   input  logic                 vld_i,
   input  sym_class_e           cls_i,
   output logic [NUM_FLAGS-1:0] ev_o,
   output logic                 in_frame_o
);

   localparam int RUN_W = $clog2(IDLE_RUN + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_RUN - 1);

   mon_state_e       st_q, st_n;
   logic [RUN_W-1:0] run_q, run_n;
   logic [NUM_FLAGS-1:0] ev;
   logic             in_frame_q;

   // in-frame handling shared by FRAME and by GOT_T when no R follows
   always_comb begin
      st_n  = st_q;
      run_n = run_q;
      ev    = '0;
      if (vld_i) begin
         unique case (st_q)
            ST_HUNT: begin
               run_n = '0;
               if (cls_i == SC_J) st_n = ST_GOT_J;
               else if (cls_i != SC_IDLE) begin
                  ev[FLG_FALSE] = 1'b1;
                  st_n          = ST_RECOVER;
               end
            end
            ST_GOT_J: begin
               run_n = '0;
               if (cls_i == SC_K) st_n = ST_FRAME;
               else begin
                  ev[FLG_FALSE] = 1'b1;
                  st_n          = ST_RECOVER;
               end
            end
            ST_RECOVER: begin
               if (cls_i != SC_IDLE) run_n = '0;
               else if (run_q == RUN_LAST) begin
                  run_n = '0;
                  st_n  = ST_HUNT;
               end else run_n = run_q + 1'b1;
            end
            ST_FRAME, ST_GOT_T: begin
               if (st_q == ST_GOT_T && cls_i == SC_R) begin
                  run_n = '0;
                  st_n  = ST_HUNT;
               end else begin
                  st_n  = ST_FRAME;
                  run_n = '0;
                  unique case (cls_i)
                     SC_T:   st_n = ST_GOT_T;
                     SC_H: begin
                        ev[FLG_HALT] = 1'b1;
                        st_n         = ST_HUNT;
                     end
                     SC_BAD: ev[FLG_INVALID] = 1'b1;
                     SC_IDLE: begin
                        if (run_q == RUN_LAST) begin
                           ev[FLG_EARLY] = 1'b1;
                           st_n          = ST_HUNT;
                        end else run_n = run_q + 1'b1;
                     end
                     default: ;
                  endcase
               end
            end
            default: begin
               st_n  = ST_HUNT;
               run_n = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_HUNT;
         run_q      <= '0;
         in_frame_q <= 1'b0;
      end else if (!enable_i) begin
         st_q       <= ST_HUNT;
         run_q      <= '0;
         in_frame_q <= 1'b0;
      end else begin
         st_q       <= st_n;
         run_q      <= run_n;
         in_frame_q <= (st_n == ST_FRAME) || (st_n == ST_GOT_T);
      end
   end

   assign ev_o       = enable_i ? ev : '0;
   assign in_frame_o = in_frame_q;

endmodule

// File: rtl/sem_sticky_bank.sv
module sem_sticky_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable_i,
   input  logic         clr_i,
   input  logic [N-1:0] set_i,
   output logic [N-1:0] q_o
);

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          bit_q <= 1'b0;
         else if (!enable_i)  bit_q <= 1'b0;
         else if (set_i[b])   bit_q <= 1'b1;
         else if (clr_i)      bit_q <= 1'b0;
      end
      assign q_o[b] = bit_q;
   end

endmodule

// File: rtl/sym_err_mon.sv
module sym_err_mon
   import sem_pkg::*;
#(
   parameter int                   CODE_W   = 5,
   parameter int                   IDLE_RUN = 2,
   parameter logic [NUM_FLAGS-1:0] ERR_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CODE_W-1:0]    code_i,
   input  logic                 code_vld_i,
   input  logic                 fast_mode_i,
   input  logic                 stat_rd_i,
   output logic [NUM_FLAGS-1:0] stat_o,
   output logic                 rx_err_o,
   output logic                 in_pkt_o
);

   if (CODE_W != 5) begin : g_bad_width
      $error("sym_err_mon: CODE_W must be 5 for 4B/5B code groups");
   end
   if (IDLE_RUN < 2) begin : g_bad_run
      $error("sym_err_mon: IDLE_RUN must be at least 2");
   end

   sym_class_e           cls;
   logic [NUM_FLAGS-1:0] ev;
   logic [NUM_FLAGS-1:0] ev_err;
   logic                 err_q;

   sem_classifier #(.CODE_W(CODE_W)) u_cls (
      .code_i (code_i),
      .cls_o  (cls)
   );

   sem_frame_fsm #(.IDLE_RUN(IDLE_RUN)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_i   (fast_mode_i),
      .vld_i      (code_vld_i),
      .cls_i      (cls),
      .ev_o       (ev),
      .in_frame_o (in_pkt_o)
   );

   sem_sticky_bank #(.N(NUM_FLAGS)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (fast_mode_i),
      .clr_i    (stat_rd_i),
      .set_i    (ev),
      .q_o      (stat_o)
   );

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_mask
      if (ERR_MASK[i]) begin : g_on
         assign ev_err[i] = ev[i];
      end else begin : g_off
         assign ev_err[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= |ev_err;
   end

   assign rx_err_o = err_q;

endmodule

// File: rtl/sem_checker.sv
module sem_checker #(
   parameter logic [3:0] ERR_MASK = 4'b1111
) (
   input logic       clk,
   input logic       rst_n,
   input logic       code_vld_i,
   input logic       fast_mode_i,
   input logic       stat_rd_i,
   input logic [3:0] stat_o,
   input logic       rx_err_o,
   input logic       in_pkt_o
);

   // R10
   slow_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_mode_i |=> (stat_o == 4'b0000 && !rx_err_o && !in_pkt_o));

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_mode_i && !stat_rd_i) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

   // R11
   no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_mode_i && !code_vld_i && !stat_rd_i) |=>
         ($stable(stat_o) && $stable(in_pkt_o) && !rx_err_o));

   // R7
   err_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|((stat_o & ~$past(stat_o)) & ERR_MASK)) |-> rx_err_o);

   // R5
   halt_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[2]) |-> !in_pkt_o);

   // R6
   early_end_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[3]) |-> !in_pkt_o);

   // R3
   false_carrier_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[0]) |-> !in_pkt_o);

endmodule

bind sym_err_mon sem_checker #(.ERR_MASK(ERR_MASK)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .code_vld_i  (code_vld_i),
   .fast_mode_i (fast_mode_i),
   .stat_rd_i   (stat_rd_i),
   .stat_o      (stat_o),
   .rx_err_o    (rx_err_o),
   .in_pkt_o    (in_pkt_o)
);

// File: tb/tb_sym_err_mon.sv
`timescale 1ns/1ps
module tb_sym_err_mon;

   localparam logic [4:0] I  = 5'b11111;
   localparam logic [4:0] J  = 5'b11000;
   localparam logic [4:0] K  = 5'b10001;
   localparam logic [4:0] T  = 5'b01101;
   localparam logic [4:0] R  = 5'b00111;
   localparam logic [4:0] H  = 5'b00100;
   localparam logic [4:0] D0 = 5'b11110;
   localparam logic [4:0] D5 = 5'b01011;
   localparam logic [4:0] BAD = 5'b00000;
   localparam logic [4:0] BAD2 = 5'b11001;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] code = I;
   logic       vld = 1'b0;
   logic       mode = 1'b1;
   logic       rd = 1'b0;
   logic [3:0] stat;
   logic       rx_err;
   logic       in_pkt;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sym_err_mon dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .code_i      (code),
      .code_vld_i  (vld),
      .fast_mode_i (mode),
      .stat_rd_i   (rd),
      .stat_o      (stat),
      .rx_err_o    (rx_err),
      .in_pkt_o    (in_pkt)
   );

   typedef struct {
      logic [3:0] stat;
      logic       err;
      logic       pkt;
      string      tag;
   } item_t;

   item_t exp_q[$];

   // reference model: 0 hunt, 1 got J, 2 frame, 3 got T, 4 recover
   int         m_st = 0;
   int         m_run = 0;
   logic [3:0] m_stat = '0;

   function automatic int kind(input logic [4:0] c);
      case (c)
         I: return 1;
         J: return 2;
         K: return 3;
         T: return 4;
         R: return 5;
         H: return 6;
         5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
         5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
         5'b11010, 5'b11011, 5'b11100, 5'b11101: return 0;
         default: return 7;
      endcase
   endfunction

   task automatic compare(input item_t got, input item_t e);
      checks++;
      if (got.stat !== e.stat || got.err !== e.err || got.pkt !== e.pkt) begin
         errors++;
         $display("FAIL %s: stat=%b err=%b pkt=%b expected stat=%b err=%b pkt=%b",
                  e.tag, got.stat, got.err, got.pkt, e.stat, e.err, e.pkt);
      end
   endtask

   task automatic send(input logic [4:0] c, input string tag,
                       input bit v = 1'b1, input bit m = 1'b1, input bit r = 1'b0);
      item_t e;
      logic [3:0] ev;
      int k;
      @(negedge clk);
      code = c; vld = v; mode = m; rd = r;
      ev = '0;
      k = kind(c);
      if (!m) begin
         m_st = 0; m_run = 0; m_stat = '0;
      end else begin
         if (v) begin
            case (m_st)
               0: begin
                  if (k == 2) m_st = 1;
                  else if (k != 1) begin ev[0] = 1'b1; m_st = 4; m_run = 0; end
               end
               1: begin
                  if (k == 3) begin m_st = 2; m_run = 0; end
                  else begin ev[0] = 1'b1; m_st = 4; m_run = 0; end
               end
               4: begin
                  if (k != 1) m_run = 0;
                  else begin
                     m_run++;
                     if (m_run == 2) begin m_st = 0; m_run = 0; end
                  end
               end
               default: begin
                  if (m_st == 3 && k == 5) begin m_st = 0; m_run = 0; end
                  else begin
                     m_st = 2;
                     if (k == 1) begin
                        m_run++;
                        if (m_run == 2) begin ev[3] = 1'b1; m_st = 0; m_run = 0; end
                     end else begin
                        m_run = 0;
                        if (k == 4) m_st = 3;
                        else if (k == 6) begin ev[2] = 1'b1; m_st = 0; end
                        else if (k == 7) ev[1] = 1'b1;
                     end
                  end
               end
            endcase
         end
         m_stat = (r ? 4'b0000 : m_stat) | ev;
      end
      e.stat = m_stat;
      e.err  = m && (ev != 0);
      e.pkt  = m && (m_st == 2 || m_st == 3);
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compares outputs 5 ns after each edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            item_t got;
            item_t e;
            e = exp_q.pop_front();
            got.stat = stat; got.err = rx_err; got.pkt = in_pkt; got.tag = "";
            compare(got, e);
         end
      end
   end

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check_reset(input string tag);
      checks++;
      if (stat !== 4'b0000 || rx_err !== 1'b0 || in_pkt !== 1'b0) begin
         errors++;
         $display("FAIL %s: stat=%b err=%b pkt=%b expected stat=0000 err=0 pkt=0",
                  tag, stat, rx_err, in_pkt);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_reset("R1 in reset");
      rst_n = 1'b1;
      @(posedge clk); #5;
      check_reset("R1 after release");

      // clean frame
      send(I, "R2"); send(I, "R2"); send(J, "R2"); send(K, "R2");
      send(D0, "R2"); send(D5, "R2"); send(D0, "R2"); send(T, "R2");
      send(R, "R2"); send(I, "R2");

      // false carrier from hunt, J/K ignored during recovery
      send(D5, "R3 R7"); send(J, "R3"); send(K, "R3"); send(I, "R3");
      send(J, "R3 single idle"); send(I, "R3"); send(I, "R3");
      send(J, "R3"); send(K, "R3 new frame"); send(T, "R3"); send(R, "R3");
      send(I, "R8 read clears", 1'b1, 1'b1, 1'b1);
      send(I, "R8");
      // J not followed by K
      send(J, "R3"); send(D0, "R3 bad pair"); send(I, "R3"); send(I, "R3");
      send(I, "R8 held", 1'b1, 1'b1, 1'b0);
      send(I, "R8 read", 1'b1, 1'b1, 1'b1);

      // invalid symbol keeps the frame
      send(J, "R4"); send(K, "R4"); send(D0, "R4"); send(BAD, "R4 R7");
      send(D5, "R4 frame continues"); send(T, "R4"); send(R, "R4");
      send(I, "R8", 1'b1, 1'b1, 1'b1);

      // halt
      send(J, "R5"); send(K, "R5"); send(D0, "R5"); send(H, "R5 R7");
      send(I, "R5"); send(I, "R8", 1'b1, 1'b1, 1'b1);

      // single idle inside a frame, then premature end
      send(J, "R6"); send(K, "R6"); send(D0, "R6"); send(I, "R6 single idle");
      send(D5, "R6 no flag"); send(T, "R6"); send(R, "R6");
      send(J, "R6"); send(K, "R6"); send(D0, "R6"); send(I, "R6");
      send(I, "R6 R7 early end"); send(I, "R6");
      send(I, "R8", 1'b1, 1'b1, 1'b1);

      // event and read at the same edge
      send(J, "R9"); send(K, "R9"); send(BAD2, "R9");
      send(BAD, "R9 event with read", 1'b1, 1'b1, 1'b1);
      send(H, "R9 halt with read", 1'b1, 1'b1, 1'b1);
      send(I, "R9 read clears", 1'b1, 1'b1, 1'b1);

      // no strobe
      send(J, "R11"); send(K, "R11");
      send(BAD, "R11 no strobe", 1'b0); send(H, "R11 no strobe", 1'b0);
      send(I, "R11 no strobe", 1'b0); send(I, "R11 no strobe", 1'b0);
      send(D0, "R11"); send(T, "R11"); send(R, "R11");

      // slow mode
      send(BAD, "R10", 1'b1, 1'b0); send(J, "R10", 1'b1, 1'b0);
      send(K, "R10", 1'b1, 1'b0); send(H, "R10", 1'b1, 1'b0);
      send(I, "R10"); send(J, "R10"); send(K, "R10 in frame");
      send(D0, "R10 drop frame", 1'b1, 1'b0);
      send(D5, "R10 back to hunt");
      send(I, "R10 clears bit", 1'b1, 1'b0);
      send(I, "R10"); send(I, "R10"); send(I, "R10");
      send(I, "R10 final", 1'b0);
      send(I, "R11 tail", 1'b0);

      @(posedge clk); #6;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule